// File: doc/BRIEF.md
# Multi-Core Inter-Processor Interrupt Controller

This block gives each of `NCORE` processor cores a small private register slice: a 32-bit pending-status word, a 32-bit enable mask, a write-one-to-set port, a write-one-to-clear port and eight 32-bit mailbox words. Every core drives one interrupt line. Any core can also post a numbered vector into another core's status word through a shared send-command register. The target core number and a 5-bit vector are decoded into a one-hot set on the target.

The block has `NPORT` request ports that work in parallel. Each port carries a requester core number, which picks the slice being accessed. A port's request is taken when `req_valid` is high. `req_ready` is held high, so the block never applies back-pressure. Exactly one cycle after a request is taken, a response appears on the same port with `rsp_valid` high. The response has no ready signal, so the consumer must take every response in the cycle it appears. Requests from different ports in the same cycle may touch the same core. Their effects are merged as described below.

The interrupt line is only changed by set or clear activity, and its raise and lower rules are not symmetric. A set can raise the line. A clear can lower it only when the status word becomes empty while the enable mask is non-empty.

Top module: `ipi_ctrl`

## Requirements
- R1: During reset and after it, every status word, enable mask and mailbox word reads zero, every `irq` bit is low, and no response is pending.
- R2: A write to the set port (offset 0x08) ORs the written value into the requester's status. Status (offset 0x00) is read-only: writes to it change nothing. Status changes only through set, clear or send activity.
- R3: After any set write, including a write of zero, `irq` for that core goes high if (status OR value) AND enable is non-zero. Writing the enable mask (offset 0x04) never changes `irq` by itself.
- R4: A write to the clear port (offset 0x0C) clears the written bits in status. `irq` falls only when the resulting status is zero and the enable mask is non-zero. Otherwise `irq` keeps its value, including when a clear of zero is written.
- R5: Mailbox words sit at offsets 0x20 to 0x3C, with word index (offset − 0x20) >> 2. Each core has its own eight words, which read back the value last written.
- R6: A write to offset 0x40 is a send command. Bits 25:16 of the data select the target core and bits 4:0 select the vector. Other data bits are ignored. The command acts like a set write of 1<<vector on the target core, with the same `irq` rule.
- R7: Any access whose requester number is NCORE or more, and any send command whose target is NCORE or more, responds with `rsp_err` high and data zero, and changes no state.
- R8: Only address bits 7:0 are decoded, and bits 1:0 of those are ignored. Offsets 0x10–0x1F and 0x44–0xFF read as zero and ignore writes. The set, clear and send offsets read as zero. Every write response carries data zero.
- R9: Each accepted request produces exactly one response, on its own port, one cycle later. Read data shows the state before any write accepted in the same cycle.
- R10: In a cycle where several ports set and clear bits on the same core, all sets (including sends) are ORed in first and all clears are applied afterwards. The `irq` rule of R3 is judged on the merged set, and then the rule of R4 on the final status.
- R11: When several ports write the same enable mask or the same mailbox word in one cycle, the highest-numbered port's data is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | NPORT | Request present, one bit per port |
| req_ready | output | NPORT | Request accepted; held high |
| req_write | input | NPORT | 1 = write, 0 = read |
| req_addr | input | NPORT×ADDR_W | Byte address; low 8 bits decoded |
| req_rid | input | NPORT×RID_W | Requester core number |
| req_wdata | input | NPORT×32 | Write data, little-endian word |
| rsp_valid | output | NPORT | Response present, one cycle after a request |
| rsp_err | output | NPORT | Decode error for the answered request |
| rsp_rdata | output | NPORT×32 | Read data, zero for writes and errors |
| irq | output | NCORE | Interrupt line of each core |

## Verification
Because there are two request ports, a set (or send) and a clear can reach the same core's status in one cycle. In the same way, two enable or mailbox writes can target one register together. The bench drives both ports in the same cycle. In one case the set and clear bits overlap, so the outcome shows whether the set was applied before the clear. In another case a merged zero-value set raises `irq` while a partial clear leaves status non-empty. The bench judges each outcome by reading status, enable and mailbox words back and by sampling `irq`. It also sends a read on one port while the other port sets bits, to confirm that the read returns the old value.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int WORD_W     = 32;
  localparam int OFS_W      = 8;
  localparam int MBOX_N     = 8;
  localparam int MBOX_IDX_W = $clog2(MBOX_N);
  localparam int TGT_LSB    = 16;
  localparam int TGT_W      = 10;
  localparam int VEC_W      = 5;

  localparam logic [OFS_W-1:0] OFS_STAT  = 8'h00;
  localparam logic [OFS_W-1:0] OFS_EN    = 8'h04;
  localparam logic [OFS_W-1:0] OFS_SET   = 8'h08;
  localparam logic [OFS_W-1:0] OFS_CLR   = 8'h0C;
  localparam logic [OFS_W-1:0] MBOX_BASE = 8'h20;
  localparam logic [OFS_W-1:0] OFS_SEND  = 8'h40;

  typedef enum logic [2:0] {
    RK_NONE, RK_STAT, RK_EN, RK_SET, RK_CLR, RK_MBOX, RK_SEND
  } reg_kind_e;

  // Word-aligned decode of the in-window offset.
  function automatic reg_kind_e classify(input logic [OFS_W-1:0] ofs);
    logic [OFS_W-1:0] w;
    w = {ofs[OFS_W-1:2], 2'b00};
    if (w == OFS_STAT)      return RK_STAT;
    else if (w == OFS_EN)   return RK_EN;
    else if (w == OFS_SET)  return RK_SET;
    else if (w == OFS_CLR)  return RK_CLR;
    else if (w == OFS_SEND) return RK_SEND;
    else if (w >= MBOX_BASE && 32'(w) < 32'(MBOX_BASE) + 4 * MBOX_N) return RK_MBOX;
    else                    return RK_NONE;
  endfunction
endpackage

// File: rtl/ipi_req_decode.sv
module ipi_req_decode
  import ipi_pkg::*;
#(
  parameter int NCORE = 4,
  parameter int RID_W = 4
) (
  input  logic                               valid,
  input  logic                               write,
  input  logic [OFS_W-1:0]                   ofs,
  input  logic [RID_W-1:0]                   rid,
  input  logic [WORD_W-1:0]                  wdata,
  output logic                               err,
  output logic                               rd_ok,
  output reg_kind_e                          kind,
  output logic [MBOX_IDX_W-1:0]              widx,
  output logic [NCORE-1:0]                   set_hit,
  output logic [NCORE-1:0][WORD_W-1:0]       set_val,
  output logic [NCORE-1:0]                   clr_hit,
  output logic [NCORE-1:0][WORD_W-1:0]       clr_val,
  output logic [NCORE-1:0]                   en_we,
  output logic [NCORE-1:0][MBOX_N-1:0]       mbox_we
);
  logic             rid_ok, tgt_ok, wr_ok;
  logic [TGT_W-1:0] tgt;

  assign kind   = classify(ofs);
  assign widx   = MBOX_IDX_W'((ofs - MBOX_BASE) >> 2);
  assign tgt    = wdata[TGT_LSB +: TGT_W];
  assign rid_ok = 32'(rid) < NCORE;
  assign tgt_ok = 32'(tgt) < NCORE;
  assign err    = valid && (!rid_ok || (write && kind == RK_SEND && !tgt_ok));
  assign wr_ok  = valid && write && !err;
  assign rd_ok  = valid && !write && !err;

  always_comb begin
    for (int c = 0; c < NCORE; c++) begin
      set_hit[c] = 1'b0;
      set_val[c] = '0;
      if (wr_ok && kind == RK_SET && 32'(rid) == c) begin
        set_hit[c] = 1'b1;
        set_val[c] = wdata;
      end
      if (wr_ok && kind == RK_SEND && 32'(tgt) == c) begin
        set_hit[c] = 1'b1;
        set_val[c] = WORD_W'(1) << wdata[VEC_W-1:0];
      end
      clr_hit[c] = wr_ok && kind == RK_CLR && 32'(rid) == c;
      clr_val[c] = clr_hit[c] ? wdata : '0;
      en_we[c]   = wr_ok && kind == RK_EN && 32'(rid) == c;
      mbox_we[c] = '0;
      if (wr_ok && kind == RK_MBOX && 32'(rid) == c) mbox_we[c][widx] = 1'b1;
    end
  end
endmodule

// File: rtl/ipi_core.sv
module ipi_core
  import ipi_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          set_hit,
  input  logic [WORD_W-1:0]             set_val,
  input  logic                          clr_hit,
  input  logic [WORD_W-1:0]             clr_val,
  input  logic                          en_we,
  input  logic [WORD_W-1:0]             en_wdata,
  input  logic [MBOX_N-1:0]             mbox_we,
  input  logic [MBOX_N-1:0][WORD_W-1:0] mbox_wdata,
  output logic [WORD_W-1:0]             status,
  output logic [WORD_W-1:0]             enable,
  output logic [MBOX_N-1:0][WORD_W-1:0] mbox,
  output logic                          irq
);
  logic [WORD_W-1:0] after_set, status_nxt;
  logic              irq_nxt;

  // Merged sets first, clears second; the line moves only on activity.
  always_comb begin
    after_set  = status | set_val;
    status_nxt = after_set & ~clr_val;
    irq_nxt    = irq;
    if (set_hit && (after_set & enable) != '0) irq_nxt = 1'b1;
    if (clr_hit && status_nxt == '0 && enable != '0) irq_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      enable <= '0;
      irq    <= 1'b0;
      mbox   <= '0;
    end else begin
      status <= status_nxt;
      irq    <= irq_nxt;
      if (en_we) enable <= en_wdata;
      for (int w = 0; w < MBOX_N; w++)
        if (mbox_we[w]) mbox[w] <= mbox_wdata[w];
    end
  end
endmodule

// File: rtl/ipi_ctrl.sv
module ipi_ctrl
  import ipi_pkg::*;
#(
  parameter int NCORE  = 4,
  parameter int NPORT  = 2,
  parameter int RID_W  = 4,
  parameter int ADDR_W = 12
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NPORT-1:0]               req_valid,
  output logic [NPORT-1:0]               req_ready,
  input  logic [NPORT-1:0]               req_write,
  input  logic [NPORT-1:0][ADDR_W-1:0]   req_addr,
  input  logic [NPORT-1:0][RID_W-1:0]    req_rid,
  input  logic [NPORT-1:0][WORD_W-1:0]   req_wdata,
  output logic [NPORT-1:0]               rsp_valid,
  output logic [NPORT-1:0]               rsp_err,
  output logic [NPORT-1:0][WORD_W-1:0]   rsp_rdata,
  output logic [NCORE-1:0]               irq
);
  // Per-port decode results
  logic [NPORT-1:0]                          p_err, p_rd_ok;
  reg_kind_e                                 p_kind [NPORT];
  logic [NPORT-1:0][MBOX_IDX_W-1:0]          p_widx;
  logic [NPORT-1:0][NCORE-1:0]               p_set_hit, p_clr_hit, p_en_we;
  logic [NPORT-1:0][NCORE-1:0][WORD_W-1:0]   p_set_val, p_clr_val;
  logic [NPORT-1:0][NCORE-1:0][MBOX_N-1:0]   p_mbox_we;

  // Merged per-core strobes
  logic [NCORE-1:0]                          m_set_hit, m_clr_hit, m_en_we;
  logic [NCORE-1:0][WORD_W-1:0]              m_set_val, m_clr_val, m_en_wd;
  logic [NCORE-1:0][MBOX_N-1:0]              m_mbox_we;
  logic [NCORE-1:0][MBOX_N-1:0][WORD_W-1:0]  m_mbox_wd;

  // Core state
  logic [NCORE-1:0][WORD_W-1:0]              core_status, core_enable;
  logic [NCORE-1:0][MBOX_N-1:0][WORD_W-1:0]  core_mbox;

  logic [NPORT-1:0][WORD_W-1:0]              rd_data;

  assign req_ready = '1;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic unused_addr_hi;
    assign unused_addr_hi = ^req_addr[p][ADDR_W-1:OFS_W];

    ipi_req_decode #(.NCORE(NCORE), .RID_W(RID_W)) u_dec (
      .valid   (req_valid[p]),
      .write   (req_write[p]),
      .ofs     (req_addr[p][OFS_W-1:0]),
      .rid     (req_rid[p]),
      .wdata   (req_wdata[p]),
      .err     (p_err[p]),
      .rd_ok   (p_rd_ok[p]),
      .kind    (p_kind[p]),
      .widx    (p_widx[p]),
      .set_hit (p_set_hit[p]),
      .set_val (p_set_val[p]),
      .clr_hit (p_clr_hit[p]),
      .clr_val (p_clr_val[p]),
      .en_we   (p_en_we[p]),
      .mbox_we (p_mbox_we[p])
    );
  end

  // Sets and clears OR together; register writes: highest port wins.
  always_comb begin
    m_set_hit = '0; m_set_val = '0;
    m_clr_hit = '0; m_clr_val = '0;
    m_en_we   = '0; m_en_wd   = '0;
    m_mbox_we = '0; m_mbox_wd = '0;
    for (int p = 0; p < NPORT; p++) begin
      for (int c = 0; c < NCORE; c++) begin
        m_set_hit[c] = m_set_hit[c] | p_set_hit[p][c];
        m_set_val[c] = m_set_val[c] | p_set_val[p][c];
        m_clr_hit[c] = m_clr_hit[c] | p_clr_hit[p][c];
        m_clr_val[c] = m_clr_val[c] | p_clr_val[p][c];
        if (p_en_we[p][c]) begin
          m_en_we[c] = 1'b1;
          m_en_wd[c] = req_wdata[p];
        end
        for (int w = 0; w < MBOX_N; w++) begin
          if (p_mbox_we[p][c][w]) begin
            m_mbox_we[c][w] = 1'b1;
            m_mbox_wd[c][w] = req_wdata[p];
          end
        end
      end
    end
  end

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    ipi_core u_core (
      .clk        (clk),
      .rst        (rst),
      .set_hit    (m_set_hit[c]),
      .set_val    (m_set_val[c]),
      .clr_hit    (m_clr_hit[c]),
      .clr_val    (m_clr_val[c]),
      .en_we      (m_en_we[c]),
      .en_wdata   (m_en_wd[c]),
      .mbox_we    (m_mbox_we[c]),
      .mbox_wdata (m_mbox_wd[c]),
      .status     (core_status[c]),
      .enable     (core_enable[c]),
      .mbox       (core_mbox[c]),
      .irq        (irq[c])
    );
  end

  // Read mux from pre-write state
  always_comb begin
    rd_data = '0;
    for (int p = 0; p < NPORT; p++) begin
      for (int c = 0; c < NCORE; c++) begin
        if (p_rd_ok[p] && 32'(req_rid[p]) == c) begin
          case (p_kind[p])
            RK_STAT: rd_data[p] = core_status[c];
            RK_EN:   rd_data[p] = core_enable[c];
            RK_MBOX: rd_data[p] = core_mbox[c][p_widx[p]];
            default: rd_data[p] = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= '0;
      rsp_err   <= '0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= p_err;
      rsp_rdata <= rd_data;
    end
  end
endmodule

// File: rtl/ipi_ctrl_chk.sv
module ipi_ctrl_chk
  import ipi_pkg::*;
#(
  parameter int NCORE = 4,
  parameter int NPORT = 2
) (
  input logic                         clk,
  input logic                         rst,
  input logic [NPORT-1:0]             req_valid,
  input logic [NPORT-1:0]             req_write,
  input logic [NPORT-1:0]             rsp_valid,
  input logic [NPORT-1:0]             rsp_err,
  input logic [NPORT-1:0][WORD_W-1:0] rsp_rdata,
  input logic [NCORE-1:0]             irq,
  input logic [NCORE-1:0]             set_hit,
  input logic [NCORE-1:0]             clr_hit,
  input logic [NCORE-1:0][WORD_W-1:0] status
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (irq == '0 && rsp_valid == '0));

  for (genvar p = 0; p < NPORT; p++) begin : g_p
    // R9
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
      req_valid[p] |=> rsp_valid[p]);
    // R9
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
      !req_valid[p] |=> !rsp_valid[p]);
    // R7
    err_only_on_rsp_chk: assert property (@(posedge clk) disable iff (rst)
      rsp_err[p] |-> (rsp_valid[p] && rsp_rdata[p] == '0));
    // R8
    wr_rsp_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (req_valid[p] && req_write[p]) |=> rsp_rdata[p] == '0);
  end

  for (genvar c = 0; c < NCORE; c++) begin : g_c
    // R3
    irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(irq[c]) |-> $past(set_hit[c]));
    // R4
    irq_fall_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(irq[c]) |-> ($past(clr_hit[c]) && status[c] == '0));
    // R2
    status_source_chk: assert property (@(posedge clk) disable iff (rst)
      !$stable(status[c]) |-> $past(set_hit[c] || clr_hit[c]));
  end
endmodule

bind ipi_ctrl ipi_ctrl_chk #(.NCORE(NCORE), .NPORT(NPORT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_write (req_write),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .rsp_rdata (rsp_rdata),
  .irq       (irq),
  .set_hit   (m_set_hit),
  .clr_hit   (m_clr_hit),
  .status    (core_status)
);

// File: tb/test_ipi_ctrl.sv
module test_ipi_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NCORE  = 4;
  localparam int NPORT  = 2;
  localparam int RID_W  = 4;
  localparam int ADDR_W = 12;

  logic                       clk = 1'b0;
  logic                       rst = 1'b1;
  logic [NPORT-1:0]           req_valid = '0;
  logic [NPORT-1:0]           req_ready;
  logic [NPORT-1:0]           req_write = '0;
  logic [NPORT-1:0][ADDR_W-1:0] req_addr = '0;
  logic [NPORT-1:0][RID_W-1:0]  req_rid = '0;
  logic [NPORT-1:0][31:0]     req_wdata = '0;
  logic [NPORT-1:0]           rsp_valid, rsp_err;
  logic [NPORT-1:0][31:0]     rsp_rdata;
  logic [NCORE-1:0]           irq;

  int checks = 0;
  int errors = 0;
  logic [32:0] q0[$];
  logic [32:0] q1[$];
  string       t0[$];
  string       t1[$];

  ipi_ctrl #(.NCORE(NCORE), .NPORT(NPORT), .RID_W(RID_W), .ADDR_W(ADDR_W)) i_ipi_ctrl (
    .clk, .rst, .req_valid, .req_ready, .req_write, .req_addr, .req_rid,
    .req_wdata, .rsp_valid, .rsp_err, .rsp_rdata, .irq
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Driver: load one port and push the expected response.
  task automatic put(int p, bit w, logic [ADDR_W-1:0] a, logic [RID_W-1:0] rid,
                     logic [31:0] d, logic [31:0] exp, bit eerr, string tag);
    req_valid[p] = 1'b1;
    req_write[p] = w;
    req_addr[p]  = a;
    req_rid[p]   = rid;
    req_wdata[p] = d;
    if (p == 0) begin q0.push_back({eerr, exp}); t0.push_back(tag); end
    else        begin q1.push_back({eerr, exp}); t1.push_back(tag); end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    req_valid = '0;
  endtask

  task automatic wr(logic [RID_W-1:0] rid, logic [ADDR_W-1:0] a, logic [31:0] d, string tag);
    put(0, 1'b1, a, rid, d, 32'h0, 1'b0, tag);
    step();
  endtask

  task automatic rd(logic [RID_W-1:0] rid, logic [ADDR_W-1:0] a, logic [31:0] exp, string tag);
    put(0, 1'b0, a, rid, 32'h0, exp, 1'b0, tag);
    step();
  endtask

  task automatic chk_irq(int c, bit e, string tag);
    @(negedge clk);
    checks++;
    if (irq[c] !== e) begin
      errors++;
      $display("FAIL %s irq[%0d]: got %0b expected %0b", tag, c, irq[c], e);
    end
  endtask

  // Monitor: pop and compare each response as it appears.
  task automatic judge(int p);
    logic [32:0] e;
    string t;
    checks++;
    if ((p == 0 && q0.size() == 0) || (p == 1 && q1.size() == 0)) begin
      errors++;
      $display("FAIL R9 port %0d: unexpected response err=%0b data=%h, expected none",
               p, rsp_err[p], rsp_rdata[p]);
      return;
    end
    if (p == 0) begin e = q0.pop_front(); t = t0.pop_front(); end
    else        begin e = q1.pop_front(); t = t1.pop_front(); end
    if ({rsp_err[p], rsp_rdata[p]} !== e) begin
      errors++;
      $display("FAIL %s port %0d: got err=%0b data=%h, expected err=%0b data=%h",
               t, p, rsp_err[p], rsp_rdata[p], e[32], e[31:0]);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (rsp_valid[0]) judge(0);
      if (rsp_valid[1]) judge(1);
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1: quiet after reset
    @(negedge clk);
    checks++;
    if (irq !== '0 || rsp_valid !== '0 || req_ready !== '1) begin
      errors++;
      $display("FAIL R1 reset outputs: irq=%h rsp_valid=%b ready=%b, expected 0/0/11",
               irq, rsp_valid, req_ready);
    end
    rd(0, 12'h000, 32'h0, "R1 status");
    rd(2, 12'h03C, 32'h0, "R1 mailbox");
    rd(3, 12'h004, 32'h0, "R1 enable");

    // R2: status read-only, set ORs in
    wr(0, 12'h000, 32'h0000_FFFF, "R2 status write");
    rd(0, 12'h000, 32'h0, "R2 status ignored");
    wr(0, 12'h008, 32'h0000_0005, "R2 set");
    rd(0, 12'h000, 32'h0000_0005, "R2 status after set");
    chk_irq(0, 1'b0, "R3 masked set");
    rd(0, 12'h008, 32'h0, "R8 set port reads zero");

    // R3: enable alone does nothing; set of zero raises
    wr(0, 12'h004, 32'h0000_0004, "R3 enable");
    chk_irq(0, 1'b0, "R3 enable write alone");
    rd(0, 12'h004, 32'h0000_0004, "R3 enable readback");
    wr(0, 12'h008, 32'h0, "R3 set zero");
    chk_irq(0, 1'b1, "R3 set of zero raises");

    // R4: partial clear holds, full clear lowers
    wr(0, 12'h00C, 32'h0000_0004, "R4 clear partial");
    chk_irq(0, 1'b1, "R4 status non-empty");
    rd(0, 12'h000, 32'h0000_0001, "R4 status after clear");
    wr(0, 12'h00C, 32'h0000_0001, "R4 clear last");
    chk_irq(0, 1'b0, "R4 empty status lowers");

    // R4: clear with enable zero keeps the line; clear of zero lowers
    wr(1, 12'h008, 32'h0000_0002, "R3 core1 set");
    chk_irq(1, 1'b0, "R3 core1 masked");
    wr(1, 12'h004, 32'h0000_0002, "R3 core1 enable");
    chk_irq(1, 1'b0, "R3 core1 enable alone");
    wr(1, 12'h008, 32'h0, "R3 core1 set zero");
    chk_irq(1, 1'b1, "R3 core1 raise");
    wr(1, 12'h004, 32'h0, "R4 core1 disable");
    wr(1, 12'h00C, 32'hFFFF_FFFF, "R4 clear with enable zero");
    chk_irq(1, 1'b1, "R4 enable zero keeps line");
    rd(1, 12'h000, 32'h0, "R4 core1 status empty");
    wr(1, 12'h004, 32'h0000_0001, "R4 core1 re-enable");
    wr(1, 12'h00C, 32'h0, "R4 clear of zero");
    chk_irq(1, 1'b0, "R4 clear of zero lowers");

    // R5: mailboxes
    wr(2, 12'h020, 32'hA5A5_0001, "R5 mbox w0");
    wr(2, 12'h03C, 32'h0BAD_F00D, "R5 mbox w7");
    wr(3, 12'h024, 32'hC0DE_0003, "R5 mbox core3 w1");
    rd(2, 12'h020, 32'hA5A5_0001, "R5 core2 w0");
    rd(2, 12'h03C, 32'h0BAD_F00D, "R5 core2 w7");
    rd(2, 12'h024, 32'h0, "R5 core2 w1 untouched");
    rd(3, 12'h024, 32'hC0DE_0003, "R5 core3 w1");
    rd(3, 12'h020, 32'h0, "R5 core3 w0 untouched");
    rd(2, 12'h03F, 32'h0BAD_F00D, "R8 low bits ignored");
    rd(2, 12'hE20, 32'hA5A5_0001, "R8 high bits ignored");

    // R6: send command
    wr(0, 12'h040, 32'h0003_001F, "R6 send vec31");
    chk_irq(3, 1'b0, "R6 target masked");
    rd(3, 12'h000, 32'h8000_0000, "R6 one-hot vec31");
    wr(3, 12'h004, 32'h8000_0000, "R6 enable core3");
    chk_irq(3, 1'b0, "R3 core3 enable alone");
    wr(1, 12'h040, 32'h0003_0102, "R6 send vec2 extra bits");
    chk_irq(3, 1'b1, "R6 send raises");
    rd(3, 12'h000, 32'h8000_0004, "R6 status after send");

    // R7: decode errors
    put(0, 1'b1, 12'h008, 4'd4, 32'h0000_00FF, 32'h0, 1'b1, "R7 bad requester write"); step();
    put(0, 1'b0, 12'h000, 4'd15, 32'h0, 32'h0, 1'b1, "R7 bad requester read"); step();
    put(0, 1'b1, 12'h040, 4'd0, 32'h0004_0001, 32'h0, 1'b1, "R7 send target 4"); step();
    put(0, 1'b1, 12'h040, 4'd0, 32'h03FF_0001, 32'h0, 1'b1, "R7 send target 1023"); step();
    rd(0, 12'h000, 32'h0, "R7 core0 unchanged");
    rd(3, 12'h000, 32'h8000_0004, "R7 core3 unchanged");

    // R8: unmapped offsets and aliasing
    wr(0, 12'h010, 32'h0000_FFFF, "R8 unmapped write");
    rd(0, 12'h010, 32'h0, "R8 unmapped 0x10");
    rd(0, 12'h044, 32'h0, "R8 unmapped 0x44");
    rd(0, 12'h040, 32'h0, "R8 send reads zero");
    rd(0, 12'h00C, 32'h0, "R8 clear reads zero");
    rd(0, 12'h000, 32'h0, "R8 status after unmapped");
    wr(0, 12'h108, 32'h0000_0010, "R8 set via alias");
    rd(0, 12'hF01, 32'h0000_0010, "R8 alias status");
    chk_irq(0, 1'b0, "R3 set outside enable");
    wr(0, 12'h00C, 32'h0000_0010, "R8 cleanup");

    // R10: same-cycle set and clear on core2
    put(0, 1'b1, 12'h008, 4'd2, 32'h0000_000F, 32'h0, 1'b0, "R10 set p0");
    put(1, 1'b1, 12'h00C, 4'd2, 32'h0000_0003, 32'h0, 1'b0, "R10 clear p1");
    step();
    rd(2, 12'h000, 32'h0000_000C, "R10 set then clear");
    put(0, 1'b1, 12'h040, 4'd0, 32'h0002_0008, 32'h0, 1'b0, "R10 send p0");
    put(1, 1'b1, 12'h040, 4'd1, 32'h0002_0009, 32'h0, 1'b0, "R10 send p1");
    step();
    rd(2, 12'h000, 32'h0000_030C, "R10 two sends merged");
    wr(2, 12'h004, 32'h0000_0100, "R10 enable core2");
    put(0, 1'b1, 12'h008, 4'd2, 32'h0, 32'h0, 1'b0, "R10 set zero p0");
    put(1, 1'b1, 12'h00C, 4'd2, 32'h0000_0003, 32'h0, 1'b0, "R10 clear p1");
    step();
    chk_irq(2, 1'b1, "R10 merged set raises");
    rd(2, 12'h000, 32'h0000_030C, "R10 status kept");
    put(0, 1'b1, 12'h008, 4'd2, 32'h0000_0001, 32'h0, 1'b0, "R10 set p0");
    put(1, 1'b1, 12'h00C, 4'd2, 32'hFFFF_FFFF, 32'h0, 1'b0, "R10 clear all p1");
    step();
    chk_irq(2, 1'b0, "R10 clear after set lowers");
    rd(2, 12'h000, 32'h0, "R10 clear wins over set");

    // R11: same-register writes, highest port wins
    put(0, 1'b1, 12'h004, 4'd1, 32'h0000_0011, 32'h0, 1'b0, "R11 en p0");
    put(1, 1'b1, 12'h004, 4'd1, 32'h0000_0022, 32'h0, 1'b0, "R11 en p1");
    step();
    rd(1, 12'h004, 32'h0000_0022, "R11 enable port1 wins");
    put(0, 1'b1, 12'h028, 4'd1, 32'h0000_AAAA, 32'h0, 1'b0, "R11 mbox p0");
    put(1, 1'b1, 12'h028, 4'd1, 32'h0000_BBBB, 32'h0, 1'b0, "R11 mbox p1");
    step();
    rd(1, 12'h028, 32'h0000_BBBB, "R11 mailbox port1 wins");
    put(0, 1'b1, 12'h02C, 4'd1, 32'h0000_0001, 32'h0, 1'b0, "R11 mbox w3");
    put(1, 1'b1, 12'h030, 4'd1, 32'h0000_0002, 32'h0, 1'b0, "R11 mbox w4");
    step();
    rd(1, 12'h02C, 32'h0000_0001, "R11 distinct word p0");
    rd(1, 12'h030, 32'h0000_0002, "R11 distinct word p1");

    // R9: read sees pre-write state in the same cycle
    put(0, 1'b0, 12'h000, 4'd0, 32'h0, 32'h0, 1'b0, "R9 read old value");
    put(1, 1'b1, 12'h008, 4'd0, 32'h0000_0040, 32'h0, 1'b0, "R9 concurrent set");
    step();
    rd(0, 12'h000, 32'h0000_0040, "R9 read new value");
    put(0, 1'b0, 12'h020, 4'd2, 32'h0, 32'hA5A5_0001, 1'b0, "R9 dual read p0");
    put(1, 1'b0, 12'h024, 4'd3, 32'h0, 32'hC0DE_0003, 1'b0, "R9 dual read p1");
    step();

    repeat (4) @(negedge clk);
    checks++;
    if (q0.size() != 0 || q1.size() != 0) begin
      errors++;
      $display("FAIL R9 missing responses: got %0d/%0d pending, expected 0/0",
               q0.size(), q1.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule